// File: doc/BRIEF.md
# MMU Access Check and TLB Search

This block sits on the access path of a processor's memory management unit. Each request has an access kind, an effective page number and the processor's mode bits (problem state, instruction space, data space). The block looks the page up in a small, fully associative table of translation entries. Every entry carries an address-space tag. The space value that the tag must equal depends on the kind of access: the instruction-space bit for fetches, the data-space bit for data traffic, and a software-set search-space bit for the table-search instruction. That last source lets privileged code look for entries that belong to an address space other than the one now running.

Two enables in the control inputs guard cache-line removal from user code. A data-cache flush or an instruction-cache invalidate issued in problem state, with the matching enable set, becomes a cache-locking storage exception and is not passed on to the cache. The pipeline must make this decision before lock state or hit status is known, so the decision uses only the mode bit and the enable. Hit, lowest matching index, exception cause and the cache-forward flag are all registered and appear one cycle after the request. A separate write port loads table entries.

Top module: `mmu_access_check`

## Requirements
- R1: After reset every table entry is invalid and all response outputs are 0, so no lookup hits until an entry is written.
- R2: For an instruction fetch (kind code 0), an entry's space tag is compared with `msr_is`.
- R3: For a data load/store (kind 1), a data-cache flush (kind 3) and an instruction-cache invalidate (kind 4), an entry's space tag is compared with `msr_ds`.
- R4: For a table-search instruction (kind 2), an entry's space tag is compared with `ctl_search_space`, whatever the MSR space bits are.
- R5: An entry hits only when it is valid and both its page number and its space tag match. `rsp_hit` is set when any entry hits, and `rsp_idx` gives the lowest-numbered hitting entry. On a miss `rsp_idx` is 0.
- R6: A request with a known kind (codes 0 to 4) gives `rsp_valid`=1 with its results exactly one clock later. A cycle with no request leaves every response output at 0 in the next cycle.
- R7: A data-cache flush with `msr_pr`=1 and `ctl_dunlock_en`=1 gives `rsp_cause`=2'b01 and `cache_op_fwd`=0.
- R8: An instruction-cache invalidate with `msr_pr`=1 and `ctl_iunlock_en`=1 gives `rsp_cause`=2'b10 and `cache_op_fwd`=0.
- R9: The exception decision of R7/R8 does not depend on whether the page hits or misses, and the enable of the other operation has no effect on it.
- R10: A flush or invalidate in supervisor mode (`msr_pr`=0), or with its enable at 0, gives `rsp_cause`=2'b00 and `cache_op_fwd`=1. Other kinds never set `cache_op_fwd` or a nonzero cause.
- R11: A table write changes the entry at `wr_idx` from the next cycle on. A lookup in the same cycle as the write sees the old contents.
- R12: A request with kind codes 5 to 7 is ignored: no response and all outputs 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Access kind: 0 fetch, 1 load/store, 2 table search, 3 data flush, 4 instruction invalidate |
| req_epn | input | EPN_W | Effective page number to look up |
| msr_pr | input | 1 | Problem state (1 = user mode) |
| msr_is | input | 1 | Instruction address space |
| msr_ds | input | 1 | Data address space |
| ctl_dunlock_en | input | 1 | Block user-mode data-cache flushes |
| ctl_iunlock_en | input | 1 | Block user-mode instruction-cache invalidates |
| ctl_search_space | input | 1 | Space value used by the table-search instruction |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Entry to write |
| wr_valid | input | 1 | Valid bit to store |
| wr_ts | input | 1 | Space tag to store |
| wr_epn | input | EPN_W | Page number to store |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_hit | output | 1 | Some entry matched |
| rsp_idx | output | IDX_W | Lowest matching entry |
| rsp_cause | output | 2 | 00 none, 01 flush blocked, 10 invalidate blocked |
| cache_op_fwd | output | 1 | Flush/invalidate passed on to the cache |

## Verification
The properties assume that only `req_valid` and `req_kind` decide whether a request is live, and that the mode and enable bits are stable over the cycle in which they are sampled. They make no assumption about table contents, so they cover both hits and misses. The stimulus drives every input half a period away from the sampling edge and changes them only between edges. It mixes directed space-selection cases and duplicate entries with random traffic, including writes that land in the same cycle as a lookup of the same page.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;

    typedef enum logic [2:0] {
        ACC_FETCH  = 3'd0,
        ACC_LDST   = 3'd1,
        ACC_SEARCH = 3'd2,
        ACC_DFLUSH = 3'd3,
        ACC_IINVAL = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_DFLUSH = 2'b01,
        CAUSE_IINVAL = 2'b10
    } lock_cause_e;

    function automatic logic kind_known(input logic [2:0] k);
        return k <= 3'd4;
    endfunction

endpackage

// File: rtl/mmu_tlb_store.sv
module mmu_tlb_store #(
    parameter int ENTRIES = 8,
    parameter int EPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic                     wr_valid,
    input  logic                     wr_ts,
    input  logic [EPN_W-1:0]         wr_epn,
    output logic [ENTRIES-1:0]       ent_valid,
    output logic [ENTRIES-1:0]       ent_ts,
    output logic [ENTRIES*EPN_W-1:0] ent_epn
);

    typedef struct packed {
        logic [ENTRIES-1:0]       valid;
        logic [ENTRIES-1:0]       ts;
        logic [ENTRIES*EPN_W-1:0] epn;
    } table_t;

    table_t tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (wr_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    tab_d.valid[i]              = wr_valid;
                    tab_d.ts[i]                 = wr_ts;
                    tab_d.epn[i*EPN_W +: EPN_W] = wr_epn;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    assign ent_valid = tab_q.valid;
    assign ent_ts    = tab_q.ts;
    assign ent_epn   = tab_q.epn;

endmodule

// File: rtl/mmu_tlb_match.sv
module mmu_tlb_match #(
    parameter int ENTRIES = 8,
    parameter int EPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]       ent_valid,
    input  logic [ENTRIES-1:0]       ent_ts,
    input  logic [ENTRIES*EPN_W-1:0] ent_epn,
    input  logic [EPN_W-1:0]         look_epn,
    input  logic                     look_ts,
    output logic                     hit,
    output logic [IDX_W-1:0]         idx
);

    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_valid[g]
                       && (ent_ts[g] == look_ts)
                       && (ent_epn[g*EPN_W +: EPN_W] == look_epn);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mmu_lock_guard.sv
module mmu_lock_guard
    import mmu_chk_pkg::*;
(
    input  logic [2:0] kind,
    input  logic       pr,
    input  logic       dunlock_en,
    input  logic       iunlock_en,
    output logic [1:0] cause,
    output logic       fwd
);

    always_comb begin
        cause = CAUSE_NONE;
        fwd   = 1'b0;
        case (kind)
            ACC_DFLUSH: begin
                if (pr && dunlock_en) cause = CAUSE_DFLUSH;
                else                  fwd   = 1'b1;
            end
            ACC_IINVAL: begin
                if (pr && iunlock_en) cause = CAUSE_IINVAL;
                else                  fwd   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mmu_access_check.sv
module mmu_access_check
    import mmu_chk_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int EPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_kind,
    input  logic [EPN_W-1:0] req_epn,
    input  logic             msr_pr,
    input  logic             msr_is,
    input  logic             msr_ds,
    input  logic             ctl_dunlock_en,
    input  logic             ctl_iunlock_en,
    input  logic             ctl_search_space,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic             wr_ts,
    input  logic [EPN_W-1:0] wr_epn,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [IDX_W-1:0] rsp_idx,
    output logic [1:0]       rsp_cause,
    output logic             cache_op_fwd
);

    typedef struct packed {
        logic             vld;
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [1:0]       cause;
        logic             fwd;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [ENTRIES-1:0]       ent_valid;
    logic [ENTRIES-1:0]       ent_ts;
    logic [ENTRIES*EPN_W-1:0] ent_epn;
    logic                     look_ts;
    logic                     m_hit;
    logic [IDX_W-1:0]         m_idx;
    logic [1:0]               g_cause;
    logic                     g_fwd;

    mmu_tlb_store #(.ENTRIES(ENTRIES), .EPN_W(EPN_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_valid  (wr_valid),
        .wr_ts     (wr_ts),
        .wr_epn    (wr_epn),
        .ent_valid (ent_valid),
        .ent_ts    (ent_ts),
        .ent_epn   (ent_epn)
    );

    mmu_tlb_match #(.ENTRIES(ENTRIES), .EPN_W(EPN_W)) u_match (
        .ent_valid (ent_valid),
        .ent_ts    (ent_ts),
        .ent_epn   (ent_epn),
        .look_epn  (req_epn),
        .look_ts   (look_ts),
        .hit       (m_hit),
        .idx       (m_idx)
    );

    mmu_lock_guard u_guard (
        .kind       (req_kind),
        .pr         (msr_pr),
        .dunlock_en (ctl_dunlock_en),
        .iunlock_en (ctl_iunlock_en),
        .cause      (g_cause),
        .fwd        (g_fwd)
    );

    // Space value each kind of access must find in an entry's tag
    always_comb begin
        case (req_kind)
            ACC_FETCH:  look_ts = msr_is;
            ACC_SEARCH: look_ts = ctl_search_space;
            default:    look_ts = msr_ds;
        endcase
    end

    always_comb begin
        rsp_d = '0;
        if (req_valid && kind_known(req_kind)) begin
            rsp_d.vld   = 1'b1;
            rsp_d.hit   = m_hit;
            rsp_d.idx   = m_idx;
            rsp_d.cause = g_cause;
            rsp_d.fwd   = g_fwd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid    = rsp_q.vld;
    assign rsp_hit      = rsp_q.hit;
    assign rsp_idx      = rsp_q.idx;
    assign rsp_cause    = rsp_q.cause;
    assign cache_op_fwd = rsp_q.fwd;

endmodule

// File: rtl/mmu_access_check_sva.sv
module mmu_access_check_sva #(
    parameter int IDX_W = 3,
    parameter int EPN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_kind,
    input logic             msr_pr,
    input logic             ctl_dunlock_en,
    input logic             ctl_iunlock_en,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [IDX_W-1:0] rsp_idx,
    input logic [1:0]       rsp_cause,
    input logic             cache_op_fwd
);

    logic live;
    assign live = req_valid && (req_kind <= 3'd4);

    p_known_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> rsp_valid);

    p_unknown_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> (!rsp_valid && !rsp_hit && rsp_idx == '0
                   && rsp_cause == 2'b00 && !cache_op_fwd));

    p_dflush_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd3 && msr_pr && ctl_dunlock_en)
        |=> (rsp_cause == 2'b01 && !cache_op_fwd));

    p_iinval_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd4 && msr_pr && ctl_iunlock_en)
        |=> (rsp_cause == 2'b10 && !cache_op_fwd));

    p_allow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ((req_kind == 3'd3 && !(msr_pr && ctl_dunlock_en))
                    || (req_kind == 3'd4 && !(msr_pr && ctl_iunlock_en))))
        |=> (rsp_cause == 2'b00 && cache_op_fwd));

    p_cause_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_cause));

    p_hit_needs_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

endmodule

bind mmu_access_check mmu_access_check_sva #(.IDX_W(IDX_W), .EPN_W(EPN_W)) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_kind       (req_kind),
    .msr_pr         (msr_pr),
    .ctl_dunlock_en (ctl_dunlock_en),
    .ctl_iunlock_en (ctl_iunlock_en),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_idx        (rsp_idx),
    .rsp_cause      (rsp_cause),
    .cache_op_fwd   (cache_op_fwd)
);

// File: tb/test_mmu_access_check.sv
module test_mmu_access_check;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 8;
    localparam int EPN_W      = 20;
    localparam int IDX_W      = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic [2:0]       req_kind;
    logic [EPN_W-1:0] req_epn;
    logic             msr_pr, msr_is, msr_ds;
    logic             ctl_dunlock_en, ctl_iunlock_en, ctl_search_space;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_valid, wr_ts;
    logic [EPN_W-1:0] wr_epn;
    logic             rsp_valid, rsp_hit, cache_op_fwd;
    logic [IDX_W-1:0] rsp_idx;
    logic [1:0]       rsp_cause;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;

    // Behavioural model of the table
    bit m_valid [ENTRIES];
    bit m_ts    [ENTRIES];
    int m_epn   [ENTRIES];

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_access_check #(.ENTRIES(ENTRIES), .EPN_W(EPN_W)) i_mmu_access_check (
        .clk, .rst_n, .req_valid, .req_kind, .req_epn, .msr_pr, .msr_is, .msr_ds,
        .ctl_dunlock_en, .ctl_iunlock_en, .ctl_search_space,
        .wr_en, .wr_idx, .wr_valid, .wr_ts, .wr_epn,
        .rsp_valid, .rsp_hit, .rsp_idx, .rsp_cause, .cache_op_fwd
    );

    task automatic compare(input string tag, input bit ev, input bit eh,
                           input int ei, input int ec, input bit ef);
        n_checks++;
        if (rsp_valid !== ev || rsp_hit !== eh || int'(rsp_idx) != ei
            || int'(rsp_cause) != ec || cache_op_fwd !== ef) begin
            n_fails++;
            $display("FAIL %s: got v=%0b h=%0b i=%0d c=%0d f=%0b expected v=%0b h=%0b i=%0d c=%0d f=%0b",
                     tag, rsp_valid, rsp_hit, rsp_idx, rsp_cause, cache_op_fwd,
                     ev, eh, ei, ec, ef);
        end
    endtask

    // Inputs are already driven; predict, update model, advance, compare.
    task automatic step(input string tag);
        bit ev, eh, ef, ts;
        int ei, ec, k;
        ev = 0; eh = 0; ef = 0; ei = 0; ec = 0;
        k  = int'(req_kind);
        if (req_valid && k <= 4) begin
            ev = 1;
            if (k == 0)      ts = msr_is;
            else if (k == 2) ts = ctl_search_space;
            else             ts = msr_ds;
            for (int e = 0; e < ENTRIES; e++) begin
                if (!eh && m_valid[e] && m_ts[e] == ts && m_epn[e] == int'(req_epn)) begin
                    eh = 1; ei = e;
                end
            end
            if (k == 3) begin
                if (msr_pr && ctl_dunlock_en) ec = 1; else ef = 1;
            end
            if (k == 4) begin
                if (msr_pr && ctl_iunlock_en) ec = 2; else ef = 1;
            end
        end
        if (wr_en) begin
            m_valid[int'(wr_idx)] = wr_valid;
            m_ts[int'(wr_idx)]    = wr_ts;
            m_epn[int'(wr_idx)]   = int'(wr_epn);
        end
        @(negedge clk);
        compare(tag, ev, eh, ei, ec, ef);
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_kind = 0; req_epn = 0;
        msr_pr = 0; msr_is = 0; msr_ds = 0;
        ctl_dunlock_en = 0; ctl_iunlock_en = 0; ctl_search_space = 0;
        wr_en = 0; wr_idx = 0; wr_valid = 0; wr_ts = 0; wr_epn = 0;
    endtask

    task automatic lookup(input string tag, input int k, input int epn,
                          input bit is, input bit ds);
        idle_inputs();
        req_valid = 1; req_kind = 3'(k); req_epn = EPN_W'(epn);
        msr_is = is; msr_ds = ds;
        step(tag);
    endtask

    task automatic put(input int idx, input bit v, input bit ts, input int epn);
        idle_inputs();
        wr_en = 1; wr_idx = IDX_W'(idx); wr_valid = v; wr_ts = ts; wr_epn = EPN_W'(epn);
        step("R11");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < ENTRIES; e++) begin
            m_valid[e] = 0; m_ts[e] = 0; m_epn[e] = 0;
        end
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        compare("R1", 0, 0, 0, 0, 0);
        rst_n = 1;
        // R1: empty table misses page 0 in either space
        lookup("R1", 0, 0, 0, 0);
        lookup("R1", 1, 0, 0, 1);
        // R6: idle cycle gives no response
        idle_inputs(); step("R6");

        put(2, 1, 0, 'h12345);
        put(5, 1, 1, 'h12345);
        put(6, 1, 0, 'h12345);
        put(7, 0, 0, 'hABCDE);

        // R11: write and lookup of same page in one cycle sees old contents
        idle_inputs();
        wr_en = 1; wr_idx = 0; wr_valid = 1; wr_ts = 0; wr_epn = 'h00AAA;
        req_valid = 1; req_kind = 0; req_epn = 'h00AAA;
        step("R11");
        lookup("R11", 0, 'h00AAA, 0, 1);

        // R2: fetch follows instruction-space bit
        lookup("R2", 0, 'h12345, 0, 1);
        lookup("R2", 0, 'h12345, 1, 0);
        // R3: data traffic follows data-space bit
        lookup("R3", 1, 'h12345, 0, 1);
        lookup("R3", 1, 'h12345, 1, 0);
        lookup("R3", 3, 'h12345, 0, 1);
        lookup("R3", 4, 'h12345, 1, 0);
        // R4: search follows the control bit
        idle_inputs(); req_valid = 1; req_kind = 2; req_epn = 'h12345;
        ctl_search_space = 1; step("R4");
        idle_inputs(); req_valid = 1; req_kind = 2; req_epn = 'h12345;
        msr_is = 1; msr_ds = 1; step("R4");
        // R5: invalid entry and unknown page miss
        lookup("R5", 1, 'hABCDE, 0, 0);
        lookup("R5", 1, 'h55555, 0, 0);

        // R7 R8 R9 R10: every mode/enable mix, hit and miss
        for (int k = 3; k <= 4; k++)
            for (int m = 0; m < 16; m++) begin
                idle_inputs();
                req_valid = 1; req_kind = 3'(k);
                req_epn = m[3] ? EPN_W'('h12345) : EPN_W'('h77777);
                msr_pr = m[0]; ctl_dunlock_en = m[1]; ctl_iunlock_en = m[2];
                step((m[0] && ((k == 3) ? m[1] : m[2])) ? ((k == 3) ? "R7" : "R8") : "R10");
            end
        idle_inputs(); req_valid = 1; req_kind = 3; req_epn = 'h99999;
        msr_pr = 1; ctl_dunlock_en = 1; step("R9");

        // R12: unknown kinds ignored
        for (int k = 5; k <= 7; k++) begin
            idle_inputs(); req_valid = 1; req_kind = 3'(k); req_epn = 'h12345;
            msr_pr = 1; ctl_dunlock_en = 1; ctl_iunlock_en = 1; step("R12");
        end

        // R5: random traffic on a small page set
        for (int n = 0; n < 400; n++) begin
            req_valid = 1'($urandom);
            req_kind = 3'($urandom_range(0, 7));
            req_epn = EPN_W'($urandom_range(0, 3));
            msr_pr = 1'($urandom); msr_is = 1'($urandom); msr_ds = 1'($urandom);
            ctl_dunlock_en = 1'($urandom); ctl_iunlock_en = 1'($urandom);
            ctl_search_space = 1'($urandom);
            wr_en = ($urandom_range(0, 3) == 0);
            wr_idx = IDX_W'($urandom); wr_valid = 1'($urandom); wr_ts = 1'($urandom);
            wr_epn = EPN_W'($urandom_range(0, 3));
            step("R5");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule